// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small 8-bit processor built around one working register, the accumulator. It runs programs held in an external byte-wide memory that answers one cycle after an address is presented. Every instruction takes two bytes: an opcode byte and an operand byte. The operand is either used directly as a value or treated as an address whose contents supply the value. The core executes loads, stores, addition, subtraction, unconditional and conditional control transfers, a flag test and a flag toggle, a no-op and a halt. Opcodes from the optional extensions (I/O, multiply and divide, bitwise and shift operations) are decoded but act as no-ops.

When reset is released, the core reads the byte at the highest memory address and starts fetching instructions from the address held there. While the active-low wait input is held low, the core finishes the instruction it is running and then stops before the next fetch. The four sense-switch inputs appear in the upper half of the status byte, and the arithmetic flags occupy the lower half. Software can test or toggle either half through a bit mask.

Top module: `acc_core`

## Requirements
- R1: While reset is held, acc, ip and the four flags read zero, halted is low and dev_id reads zero. Once reset is released, ip holds the byte stored at address 0xFF two clock edges later, and instruction fetch starts at that address.
- R2: The opcode byte splits into group bits [7:6], mode bits [5:4] and index bits [3:0]. Group 01 with mode 01 (0x50–0x57) takes the operand as an immediate value. Group 01 with mode 10 (0x60–0x67) takes the value from memory at the operand address. Every instruction that does not transfer control and is not END advances ip by 2.
- R3: LDA (index 0) loads the value into acc and updates N and Z, leaving C and O unchanged. STO (index 1) writes acc to the address given by the operand byte in both modes, and no flag changes.
- R4: ADD (index 2) and SUB (index 3) write the 8-bit result to acc. C is set on carry out for ADD, or when a borrow is needed for SUB (acc < value). O is set on signed overflow, N copies result bit 7, and Z is set when the result is zero.
- R5: JMP (index 4) loads ip with the value. JEQ (index 5) does the same only when Z is set. JFL (index 6) sets ip to ip+4, skipping the next instruction, when every bit set in the value is also set in the status byte. A transfer that is not taken advances ip by 2.
- R6: FTG (index 7) XORs value bits [3:0] into the four flags. Value bits [7:4] have no effect.
- R7: The status byte holds C at bit 0, Z at bit 1, N at bit 2 and O at bit 3. Bits 7 to 4 mirror sense[3] to sense[0].
- R8: Opcode 0x00 (END) sets halted. ip keeps the address of the END instruction, and no further memory read or write happens until reset.
- R9: Opcode 0x01, and every other opcode outside 0x00 and 0x50–0x57 / 0x60–0x67 (including indices 8–15 of groups 0x5 and 0x6), changes nothing except advancing ip by 2.
- R10: While wait_n is low at an instruction boundary, the core makes no memory access and ip stays stable. The instruction already in flight completes first, and execution resumes when wait_n returns high.
- R11: An instruction takes 4 cycles, or 5 when it is indirect and not STO. With wait_n high, halted rises 2 + (sum of instruction cycles) clock edges after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_n | input | 1 | Pause request at the next instruction boundary, active low |
| sense | input | 4 | Sense-switch levels, shown in status[7:4] |
| mem_addr | output | 8 | Memory address |
| mem_rd | output | 1 | Read request; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rdata | input | 8 | Read data, registered by the memory |
| acc | output | 8 | Accumulator |
| ip | output | 8 | Instruction pointer |
| status | output | 8 | Sense switches and flags {S1..S4, O, N, Z, C} |
| dev_id | output | 8 | I/O device-select register; no core instruction writes it |
| halted | output | 1 | High once END has executed |

## Verification
The boot vector lands in ip after the second clock edge following reset release, so the bench samples it at the falling edge after that edge. Each program's final state is due when halted rises, which happens 2 + (sum of instruction cycles) edges after release, with 4 or 5 cycles per instruction and one extra cycle for each stalled edge while wait_n is held low. The bench counts edges from release, computes the expected count with its own instruction-level model, and compares acc, ip, status and the whole memory only at that point. During a wait stall, the quiet bus and the stable ip are checked at every falling edge before wait_n is released.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Operation classes after decode
  typedef enum logic [3:0] {
    OC_NOP, OC_END, OC_LDA, OC_STO, OC_ADD, OC_SUB,
    OC_JMP, OC_JEQ, OC_JFL, OC_FTG
  } op_class_e;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_BOOT_REQ, ST_BOOT_TAKE, ST_OP_REQ, ST_OP_TAKE,
    ST_ARG_TAKE, ST_DATA_TAKE, ST_EXEC, ST_HALT
  } seq_state_e;

  // Flag bit positions within the low status nibble
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_O = 3;
  localparam int FLAG_BITS = 4;

  // Opcode field codes
  localparam logic [1:0] GRP_CTRL = 2'b00;
  localparam logic [1:0] GRP_CORE = 2'b01;
  localparam logic [1:0] MODE_NONE = 2'b00;
  localparam logic [1:0] MODE_IMM  = 2'b01;
  localparam logic [1:0] MODE_IND  = 2'b10;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opcode,
  output op_class_e  cls,
  output logic       indirect,
  output logic       needs_data
);

  logic [1:0] grp;
  logic [1:0] mode;
  logic [3:0] idx;

  assign grp  = opcode[7:6];
  assign mode = opcode[5:4];
  assign idx  = opcode[3:0];

  always_comb begin
    cls      = OC_NOP;
    indirect = 1'b0;
    if (grp == GRP_CTRL && mode == MODE_NONE) begin
      cls = (idx == 4'd0) ? OC_END : OC_NOP;
    end else if (grp == GRP_CORE && (mode == MODE_IMM || mode == MODE_IND) && !idx[3]) begin
      indirect = (mode == MODE_IND);
      case (idx[2:0])
        3'd0:    cls = OC_LDA;
        3'd1:    cls = OC_STO;
        3'd2:    cls = OC_ADD;
        3'd3:    cls = OC_SUB;
        3'd4:    cls = OC_JMP;
        3'd5:    cls = OC_JEQ;
        3'd6:    cls = OC_JFL;
        default: cls = OC_FTG;
      endcase
    end
  end

  // A store uses its operand as the target address, so it never reads data
  assign needs_data = indirect && (cls != OC_STO);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  op_class_e            cls,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [FLAG_BITS-1:0] fl,
  output logic [W-1:0]         res,
  output logic                 acc_we,
  output logic [FLAG_BITS-1:0] fl_nx
);

  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // MSB of the extended difference is the borrow
  function automatic logic [W:0] sub_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic signed_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                      input logic [W-1:0] r, input logic is_sub);
    logic same_in;
    same_in = (x[W-1] == y[W-1]);
    return (is_sub ? !same_in : same_in) && (r[W-1] != x[W-1]);
  endfunction

  logic [W:0] ext;

  always_comb begin
    res    = a;
    acc_we = 1'b0;
    fl_nx  = fl;
    ext    = '0;
    case (cls)
      OC_LDA: begin
        res           = b;
        acc_we        = 1'b1;
        fl_nx[FLAG_N] = b[W-1];
        fl_nx[FLAG_Z] = (b == '0);
      end
      OC_ADD: begin
        ext           = add_ext(a, b);
        res           = ext[W-1:0];
        acc_we        = 1'b1;
        fl_nx[FLAG_C] = ext[W];
        fl_nx[FLAG_O] = signed_ovf(a, b, ext[W-1:0], 1'b0);
        fl_nx[FLAG_N] = ext[W-1];
        fl_nx[FLAG_Z] = (ext[W-1:0] == '0);
      end
      OC_SUB: begin
        ext           = sub_ext(a, b);
        res           = ext[W-1:0];
        acc_we        = 1'b1;
        fl_nx[FLAG_C] = ext[W];
        fl_nx[FLAG_O] = signed_ovf(a, b, ext[W-1:0], 1'b1);
        fl_nx[FLAG_N] = ext[W-1];
        fl_nx[FLAG_Z] = (ext[W-1:0] == '0);
      end
      OC_FTG: fl_nx = fl ^ b[FLAG_BITS-1:0];
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_n,
  input  logic       needs_data,
  input  logic       is_end,
  output seq_state_e state
);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_BOOT_REQ:  nxt = ST_BOOT_TAKE;
      ST_BOOT_TAKE: nxt = ST_OP_REQ;
      ST_OP_REQ:    nxt = wait_n ? ST_OP_TAKE : ST_OP_REQ;
      ST_OP_TAKE:   nxt = ST_ARG_TAKE;
      ST_ARG_TAKE:  nxt = needs_data ? ST_DATA_TAKE : ST_EXEC;
      ST_DATA_TAKE: nxt = ST_EXEC;
      ST_EXEC:      nxt = is_end ? ST_HALT : ST_OP_REQ;
      default:      nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_BOOT_REQ;
    else        state <= nxt;
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wait_n,
  input  logic [W-5:0] sense,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] acc,
  output logic [W-1:0] ip,
  output logic [W-1:0] status,
  output logic [W-1:0] dev_id,
  output logic         halted
);

  localparam logic [W-1:0] BOOT_ADDR = '1;
  localparam logic [W-1:0] STEP      = W'(2);
  localparam logic [W-1:0] SKIP      = W'(4);

  seq_state_e           state;
  op_class_e            cls;
  logic                 indirect;
  logic                 needs_data;
  logic [W-1:0]         acc_q, ip_q, opc_q, arg_q, val_q;
  logic [FLAG_BITS-1:0] flags_q, fl_nx;
  logic [W-1:0]         alu_res;
  logic                 acc_we;
  logic                 jump_cond;

  // Named events for the checker
  logic         in_exec;
  logic         retire;
  logic         jump_taken;
  logic [W-1:0] jump_target;
  logic         wait_stall;
  logic         ftg_exec;

  acc_decode u_dec (
    .opcode     (opc_q[7:0]),
    .cls        (cls),
    .indirect   (indirect),
    .needs_data (needs_data)
  );

  acc_alu #(.W(W)) u_alu (
    .cls    (cls),
    .a      (acc_q),
    .b      (val_q),
    .fl     (flags_q),
    .res    (alu_res),
    .acc_we (acc_we),
    .fl_nx  (fl_nx)
  );

  acc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_n     (wait_n),
    .needs_data (needs_data),
    .is_end     (cls == OC_END),
    .state      (state)
  );

  assign status = {sense, flags_q};

  always_comb begin
    case (cls)
      OC_JMP:  jump_cond = 1'b1;
      OC_JEQ:  jump_cond = flags_q[FLAG_Z];
      OC_JFL:  jump_cond = ((status & val_q) == val_q);
      default: jump_cond = 1'b0;
    endcase
  end

  assign in_exec     = (state == ST_EXEC);
  assign jump_taken  = in_exec && jump_cond;
  assign jump_target = (cls == OC_JFL) ? ip_q + SKIP : val_q;
  assign retire      = in_exec && (cls != OC_END);
  assign wait_stall  = (state == ST_OP_REQ) && !wait_n;
  assign ftg_exec    = in_exec && (cls == OC_FTG);

  // Memory request steering
  always_comb begin
    mem_addr = ip_q;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    case (state)
      ST_BOOT_REQ: begin
        mem_addr = BOOT_ADDR;
        mem_rd   = 1'b1;
      end
      ST_OP_REQ: begin
        mem_addr = ip_q;
        mem_rd   = wait_n;
      end
      ST_OP_TAKE: begin
        mem_addr = ip_q + W'(1);
        mem_rd   = 1'b1;
      end
      ST_ARG_TAKE: begin
        mem_addr = mem_rdata;
        mem_rd   = needs_data;
      end
      ST_EXEC: begin
        mem_addr = arg_q;
        mem_wr   = (cls == OC_STO);
      end
      default: ;
    endcase
  end

  assign mem_wdata = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ip_q    <= '0;
      opc_q   <= '0;
      arg_q   <= '0;
      val_q   <= '0;
      flags_q <= '0;
    end else begin
      case (state)
        ST_BOOT_TAKE: ip_q  <= mem_rdata;
        ST_OP_TAKE:   opc_q <= mem_rdata;
        ST_ARG_TAKE: begin
          arg_q <= mem_rdata;
          val_q <= mem_rdata;
        end
        ST_DATA_TAKE: val_q <= mem_rdata;
        ST_EXEC: begin
          if (acc_we) acc_q <= alu_res;
          flags_q <= fl_nx;
          if (jump_taken)         ip_q <= jump_target;
          else if (cls != OC_END) ip_q <= ip_q + STEP;
        end
        default: ;
      endcase
    end
  end

  assign acc    = acc_q;
  assign ip     = ip_q;
  assign halted = (state == ST_HALT);
  // Device-select register: only I/O-extension opcodes would load it
  assign dev_id = '0;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic [W-1:0] ip,
  input logic [3:0]   flags,
  input logic         halted,
  input logic         retire,
  input logic         jump_taken,
  input logic [W-1:0] jump_target,
  input logic         wait_stall,
  input logic         ftg_exec,
  input logic [3:0]   ftg_mask
);

  assert_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !jump_taken) |=> (ip == $past(ip) + W'(2)));

  assert_jump_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> (ip == $past(jump_target)));

  assert_flag_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ftg_exec |=> (flags == ($past(flags) ^ $past(ftg_mask))));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stall |-> (!mem_rd && !mem_wr));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stall |=> $stable(ip));

  assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind acc_core acc_core_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .ip          (ip),
  .flags       (flags_q),
  .halted      (halted),
  .retire      (retire),
  .jump_taken  (jump_taken),
  .jump_target (jump_target),
  .wait_stall  (wait_stall),
  .ftg_exec    (ftg_exec),
  .ftg_mask    (val_q[3:0])
);

// File: tb/test_acc_core.sv
module test_acc_core;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wait_n = 1'b1;
  logic [3:0] sense_v = 4'h0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, acc, ip, status, dev_id;
  logic       mem_rd, mem_wr, halted;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  int n_chk = 0;
  int n_fail = 0;
  int pc;

  acc_core #(.W(W)) i_acc_core (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n), .sense(sense_v),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc(acc), .ip(ip), .status(status), .dev_id(dev_id), .halted(halted)
  );

  // Synchronous memory, registered read
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Instruction-level reference model
  logic [7:0] r_acc, r_ip;
  logic [3:0] r_fl;
  int         r_cyc;
  bit         r_halt;

  task automatic model_run();
    logic [7:0] op, arg, v, p;
    logic [8:0] e;
    bit ind, jmp;
    r_acc = 0; r_fl = 0; r_cyc = 0; r_halt = 0;
    p = ref_mem[255];
    for (int s = 0; s < 300 && !r_halt; s++) begin
      op = ref_mem[p];
      arg = ref_mem[p + 8'd1];
      jmp = 0;
      if (op == 8'h00) begin
        r_halt = 1; r_cyc += 4;
      end else if ((op[7:4] == 4'h5 || op[7:4] == 4'h6) && op[3:0] < 4'd8) begin
        ind = (op[7:4] == 4'h6) && (op[3:0] != 4'd1);
        v = ind ? ref_mem[arg] : arg;
        r_cyc += ind ? 5 : 4;
        case (op[3:0])
          4'd0: begin r_acc = v; r_fl[2] = v[7]; r_fl[1] = (v == 0); end
          4'd1: ref_mem[arg] = r_acc;
          4'd2: begin
            e = {1'b0, r_acc} + {1'b0, v};
            r_fl[3] = (r_acc[7] == v[7]) && (e[7] != r_acc[7]);
            r_fl[0] = e[8];
            r_acc = e[7:0]; r_fl[2] = r_acc[7]; r_fl[1] = (r_acc == 0);
          end
          4'd3: begin
            e = {1'b0, r_acc} - {1'b0, v};
            r_fl[3] = (r_acc[7] != v[7]) && (e[7] != r_acc[7]);
            r_fl[0] = (r_acc < v);
            r_acc = e[7:0]; r_fl[2] = r_acc[7]; r_fl[1] = (r_acc == 0);
          end
          4'd4: begin p = v; jmp = 1; end
          4'd5: if (r_fl[1]) begin p = v; jmp = 1; end
          4'd6: if (({sense_v, r_fl} & v) == v) begin p = p + 8'd4; jmp = 1; end
          default: r_fl = r_fl ^ v[3:0];
        endcase
      end else begin
        r_cyc += 4;
      end
      if (!r_halt && !jmp) p = p + 8'd2;
    end
    r_ip = p;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input logic [7:0] op, input logic [7:0] arg);
    mem[pc[7:0]] = op;
    mem[pc[7:0] + 8'd1] = arg;
    pc += 2;
  endtask

  task automatic run_prog(input string tag, input int hold);
    int cnt, expc, bad_stall, miss;
    bit done;
    logic [7:0] boot;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    model_run();
    boot = mem[255];
    rst_n = 1'b0;
    wait_n = (hold > 0) ? 1'b0 : 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(acc == 0 && ip == 0 && status[3:0] == 0 && !halted && dev_id == 0,
          "R1 reset state", {acc, ip, status[3:0], halted}, 0);
    rst_n = 1'b1;
    cnt = 0; done = 0; bad_stall = 0;
    while (!done && cnt < 2000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 2) check(ip == boot, "R1 boot vector", ip, boot);
      if (hold > 0 && !wait_n && cnt > 2 && (mem_rd || mem_wr || ip != boot)) bad_stall++;
      if (hold > 0 && cnt == hold) wait_n = 1'b1;
      if (halted) done = 1;
    end
    expc = 2 + r_cyc + ((hold > 2) ? hold - 2 : 0);
    check(done && cnt == expc, {tag, " R11 cycles to halt"}, cnt, expc);
    if (hold > 0) check(bad_stall == 0, "R10 stall quiet", bad_stall, 0);
    check(acc == r_acc, {tag, " R3/R4 acc"}, acc, r_acc);
    check(ip == r_ip, {tag, " R2/R5/R8 ip"}, ip, r_ip);
    check(status == {sense_v, r_fl}, {tag, " R4/R6/R7 status"}, status, {sense_v, r_fl});
    miss = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) miss++;
    check(miss == 0, {tag, " R3 memory image"}, miss, 0);
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] op, arg;
    int n, kind;
    bit ind;
    void'($urandom(32'h00C0FFEE));

    // R4: carry out and zero on wrap
    clear_mem(); mem[255] = 8'h10; pc = 16'h10; sense_v = 4'h0;
    put(8'h50, 8'hFF); put(8'h52, 8'h01); put(8'h00, 8'h00);
    run_prog("R4 carry", 0);
    check(status[1:0] == 2'b11, "R4 C and Z after FF+1", status[1:0], 3);

    // R4: signed overflow both ways, borrow
    clear_mem(); mem[255] = 8'h10; pc = 16'h10;
    put(8'h50, 8'h7F); put(8'h52, 8'h01); put(8'h61, 8'h90);
    put(8'h50, 8'h80); put(8'h53, 8'h01); put(8'h61, 8'h91);
    put(8'h50, 8'h00); put(8'h53, 8'h01); put(8'h00, 8'h00);
    run_prog("R4 overflow", 0);
    check(status[3:0] == 4'b0101, "R4 N and C after 0-1", status[3:0], 5);

    // R3: indirect load, stores in both modes, indirect add
    clear_mem(); mem[255] = 8'h20; pc = 16'h20; mem[8'hA0] = 8'h5A;
    put(8'h60, 8'hA0); put(8'h51, 8'hB0); put(8'h61, 8'hB1);
    put(8'h62, 8'hA0); put(8'h00, 8'h00);
    run_prog("R3 indirect", 0);
    check(mem[8'hB1] == 8'h5A, "R3 STO indirect mode target", mem[8'hB1], 8'h5A);

    // R5/R6/R7: flag toggle, mask test on sense bits, JEQ, JMP
    clear_mem(); mem[255] = 8'h10; pc = 16'h10; sense_v = 4'hA; mem[8'hF0] = 8'h0F;
    put(8'h57, 8'hF3); put(8'h56, 8'hA3); put(8'h50, 8'h11); put(8'h55, 8'h20);
    put(8'h50, 8'h22);
    pc = 16'h20;
    put(8'h67, 8'hF0); put(8'h56, 8'h0C); put(8'h50, 8'h33); put(8'h54, 8'h30);
    pc = 16'h30;
    put(8'h00, 8'h00);
    run_prog("R5 flags", 0);
    check(status == 8'hAC, "R7 sense in high nibble, R6 toggles", status, 8'hAC);

    // R9: NOP and undefined opcodes
    clear_mem(); mem[255] = 8'h08; pc = 16'h08; sense_v = 4'h3;
    put(8'h50, 8'h3C); put(8'h01, 8'h77); put(8'h58, 8'h12); put(8'h9F, 8'h00);
    put(8'hF8, 8'h00); put(8'h07, 8'h00); put(8'h6C, 8'h80); put(8'h00, 8'h00);
    run_prog("R9 no-op", 0);
    check(acc == 8'h3C && ip == 8'h16, "R9 only ip moves", ip, 8'h16);

    // R8: immediate halt, then stays quiet
    clear_mem(); mem[255] = 8'h40; pc = 16'h40;
    put(8'h00, 8'h00);
    run_prog("R8 halt", 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(halted && ip == 8'h40 && !mem_rd && !mem_wr, "R8 halted quiet", ip, 8'h40);
    end

    // R10: wait held after reset release
    clear_mem(); mem[255] = 8'h20; pc = 16'h20; mem[8'hA0] = 8'h5A;
    put(8'h60, 8'hA0); put(8'h51, 8'hB0); put(8'h62, 8'hA0); put(8'h00, 8'h00);
    run_prog("R10 wait", 9);

    // Constrained random programs
    for (int t = 0; t < 24; t++) begin
      clear_mem();
      for (int i = 8'h80; i < 255; i++) mem[i] = 8'($urandom);
      pc = ($urandom % 8) * 2;
      mem[255] = 8'(pc);
      sense_v = 4'($urandom);
      n = 6 + ($urandom % 8);
      for (int k = 0; k < n; k++) begin
        kind = $urandom % 8;
        ind = $urandom % 2;
        if (kind < 4) begin
          op = (ind ? 8'h60 : 8'h50) | ((kind == 3) ? 8'h07 : 8'(kind == 0 ? 0 : kind));
          arg = ind ? 8'(8'h80 + ($urandom % 112)) : 8'($urandom);
        end else if (kind == 4) begin
          op = ind ? 8'h61 : 8'h51;
          arg = 8'(8'h80 + ($urandom % 112));
        end else if (kind == 5) begin
          op = (ind ? 8'h60 : 8'h50) | 8'(4 + ($urandom % 2));
          if (ind) begin
            mem[8'hF0 + k] = 8'(pc + 4);
            arg = 8'(8'hF0 + k);
          end else arg = 8'(pc + 4);
        end else if (kind == 6) begin
          op = ind ? 8'h66 : 8'h56;
          arg = ind ? 8'(8'h80 + ($urandom % 112)) : 8'($urandom & $urandom);
        end else begin
          op = 8'($urandom);
          while (op == 8'h00 || ((op[7:4] == 4'h5 || op[7:4] == 4'h6) && !op[3]))
            op = 8'($urandom);
          arg = 8'($urandom);
        end
        put(op, arg);
      end
      put(8'h00, 8'h00);
      run_prog("R2 random", (t % 6 == 5) ? 4 + ($urandom % 5) : 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule